// File: doc/BRIEF.md
# Bus and Memory Zone Controller

This block sits between a CPU bus with 16-bit data and 24-bit addresses and the memories and I/O devices behind it. When the CPU starts a cycle, the block decodes the top four address bits into one of six zones. It then drives the strobe set for that zone: an active-low chip select for ROM, SRAM or the I/O gate array, or a row strobe for one of two 4 MB DRAM banks. The two DRAM banks share one column strobe.

Reads always fetch the full word. Writes use separate strobes for the even byte and the odd byte. A WAIT line holds the CPU while a per-zone count of wait states runs down. Accesses to the top megabyte (on-chip register space) finish in one cycle and touch no external pin.

A cycle begins when `cpu_start` is high while the controller is idle. The controller latches the address, direction and byte enables on that edge. From the next cycle on, the strobes stay active for (wait count + 1) cycles. WAIT is high in every one of those cycles except the last. The controller is idle again on the following cycle.

Top module: `mem_zone_ctl`

## Requirements
- R1: Address top nibble 0x0–0x3 drives `ras_n[0]` low and 0x4–0x7 drives `ras_n[1]` low. No chip select is driven for these addresses.
- R2: Top nibble 0x8–0xB drives `rom_sel_n` low, 0xC–0xD drives `sram_sel_n` low, and 0xE drives `io_sel_n` low.
- R3: Top nibble 0xF (on-chip register space) completes in one cycle with WAIT low. During that cycle every select, RAS, CAS, OE and write strobe stays high.
- R4: A read (`cpu_wr`=0) to an external zone drives `oe_n` low and keeps both `we_n` bits high, whatever `cpu_ben` holds.
- R5: A write (`cpu_wr`=1) keeps `oe_n` high. It drives `we_n[0]` (even byte) low when `cpu_ben[0]`=1 and `we_n[1]` (odd byte) low when `cpu_ben[1]`=1; setting both bits writes the whole word.
- R6: An external access keeps `cpu_wait` high for exactly N cycles, then low for one final cycle. N is ROM_WS for ROM, SRAM_WS for SRAM, IO_WS for I/O, and DRAM_RCD+DRAM_CAS for either DRAM bank.
- R7: For DRAM, `cas_n` goes low on the last DRAM_CAS+1 cycles of the access and only while a RAS line is low. Both banks use this one `cas_n` line.
- R8: At most one of the five selects and RAS lines is low in any cycle, and all strobes are high whenever no access is in progress.
- R9: `cpu_start` while an access is in progress is ignored. The zone, direction and byte lanes of the running access do not change.
- R10: After reset every active-low output is high and `cpu_wait` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_start | input | 1 | Begin a bus cycle (accepted when idle) |
| cpu_addr | input | 24 | Byte address of the cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_ben | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| cpu_wait | output | 1 | High while the CPU must extend the cycle |
| rom_sel_n | output | 1 | ROM select, active low |
| sram_sel_n | output | 1 | SRAM select, active low |
| io_sel_n | output | 1 | I/O gate array select, active low |
| ras_n | output | 2 | DRAM row strobes, one per bank, active low |
| cas_n | output | 1 | Shared DRAM column strobe, active low |
| oe_n | output | 1 | Output enable for reads, active low |
| we_n | output | 2 | Write strobes, bit 0 even byte, bit 1 odd byte, active low |

## Verification
A corrupted latched zone shows up in the first active cycle as the wrong select or RAS line. A wrong countdown value shows up as WAIT dropping one or more cycles early or late, and for DRAM as CAS starting on the wrong cycle. A busy flag that clears too early or too late shows up in the next idle cycle as a strobe still held low, or as a second access starting when the reference model does not expect one. Because outputs are compared on every cycle, each such fault is caught within the access in which it happens.

// File: rtl/zone_pkg.sv
package zone_pkg;

    typedef enum logic [2:0] {
        ZN_BANK0,
        ZN_BANK1,
        ZN_ROM,
        ZN_SRAM,
        ZN_IO,
        ZN_LOCAL
    } zone_e;

    typedef struct packed {
        zone_e      zone;
        logic       wr;
        logic [1:0] ben;
    } acc_t;

    // Top address nibble to zone
    function automatic zone_e zone_of(input logic [3:0] nib);
        unique casez (nib)
            4'b00??: zone_of = ZN_BANK0;
            4'b01??: zone_of = ZN_BANK1;
            4'b10??: zone_of = ZN_ROM;
            4'b110?: zone_of = ZN_SRAM;
            4'b1110: zone_of = ZN_IO;
            default: zone_of = ZN_LOCAL;
        endcase
    endfunction

    function automatic logic is_dram(input zone_e z);
        return (z == ZN_BANK0) || (z == ZN_BANK1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/zone_decoder.sv
module zone_decoder
    import zone_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned ROM_WS   = 2,
    parameter int unsigned SRAM_WS  = 1,
    parameter int unsigned IO_WS    = 3,
    parameter int unsigned DRAM_RCD = 1,
    parameter int unsigned DRAM_CAS = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output zone_e             zone,
    output logic [CNT_W-1:0]  wait_cnt
);
    localparam int unsigned DRAM_WS = DRAM_RCD + DRAM_CAS;

    always_comb begin
        zone = zone_of(addr[ADDR_W-1 -: 4]);
        unique case (zone)
            ZN_BANK0, ZN_BANK1: wait_cnt = CNT_W'(DRAM_WS);
            ZN_ROM:             wait_cnt = CNT_W'(ROM_WS);
            ZN_SRAM:            wait_cnt = CNT_W'(SRAM_WS);
            ZN_IO:              wait_cnt = CNT_W'(IO_WS);
            default:            wait_cnt = '0;
        endcase
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy && load) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

    // R6
    final_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0) |=> !busy);
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import zone_pkg::*;
#(
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned DRAM_CAS = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  acc_t             acc,
    output logic             wait_o,
    output logic [2:0]       sel_n,
    output logic [1:0]       ras_n,
    output logic             cas_n,
    output logic             oe_n,
    output logic [1:0]       we_n
);
    logic ext;

    always_comb begin
        ext    = busy && (acc.zone != ZN_LOCAL);
        wait_o = busy && (cnt != '0);
        sel_n  = 3'b111;
        ras_n  = 2'b11;
        if (busy) begin
            unique case (acc.zone)
                ZN_BANK0: ras_n[0] = 1'b0;
                ZN_BANK1: ras_n[1] = 1'b0;
                ZN_ROM:   sel_n[0] = 1'b0;
                ZN_SRAM:  sel_n[1] = 1'b0;
                ZN_IO:    sel_n[2] = 1'b0;
                default:  ;
            endcase
        end
        cas_n = !(busy && is_dram(acc.zone) && (cnt <= CNT_W'(DRAM_CAS)));
        oe_n  = !(ext && !acc.wr);
        we_n  = (ext && acc.wr) ? ~acc.ben : 2'b11;
    end

    // R8
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~{sel_n, ras_n}));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&{sel_n, ras_n, cas_n, oe_n, we_n}));

    // R7
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> (ras_n != 2'b11));

    // R4
    read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (we_n == 2'b11));

    // R3
    local_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && acc.zone == ZN_LOCAL) |-> (!wait_o && &{sel_n, ras_n, cas_n, oe_n, we_n}));
endmodule

// File: rtl/mem_zone_ctl.sv
module mem_zone_ctl
    import zone_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned ROM_WS   = 2,
    parameter int unsigned SRAM_WS  = 1,
    parameter int unsigned IO_WS    = 3,
    parameter int unsigned DRAM_RCD = 1,
    parameter int unsigned DRAM_CAS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_start,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_ben,
    output logic              cpu_wait,
    output logic              rom_sel_n,
    output logic              sram_sel_n,
    output logic              io_sel_n,
    output logic [1:0]        ras_n,
    output logic              cas_n,
    output logic              oe_n,
    output logic [1:0]        we_n
);
    localparam int unsigned MAX_WS = max2(max2(ROM_WS, SRAM_WS), max2(IO_WS, DRAM_RCD + DRAM_CAS));
    localparam int unsigned CNT_W  = $clog2(MAX_WS + 2);

    zone_e            dec_zone;
    logic [CNT_W-1:0] dec_cnt;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    acc_t             acc_q;
    logic [2:0]       sel_n;

    zone_decoder #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ROM_WS(ROM_WS), .SRAM_WS(SRAM_WS),
        .IO_WS(IO_WS), .DRAM_RCD(DRAM_RCD), .DRAM_CAS(DRAM_CAS)
    ) u_dec (
        .addr(cpu_addr), .zone(dec_zone), .wait_cnt(dec_cnt)
    );

    assign accept = cpu_start && !busy;

    wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(accept), .load_val(dec_cnt),
        .busy(busy), .cnt(cnt)
    );

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '{zone: ZN_LOCAL, wr: 1'b0, ben: 2'b00};
        else if (accept) acc_q <= '{zone: dec_zone, wr: cpu_wr, ben: cpu_ben};
    end

    strobe_gen #(.CNT_W(CNT_W), .DRAM_CAS(DRAM_CAS)) u_stb (
        .clk(clk), .rst(rst), .busy(busy), .cnt(cnt), .acc(acc_q),
        .wait_o(cpu_wait), .sel_n(sel_n), .ras_n(ras_n), .cas_n(cas_n),
        .oe_n(oe_n), .we_n(we_n)
    );

    assign rom_sel_n  = sel_n[0];
    assign sram_sel_n = sel_n[1];
    assign io_sel_n   = sel_n[2];

    // R9
    hold_access_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> $stable(acc_q));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_wait && &{rom_sel_n, sram_sel_n, io_sel_n, ras_n, cas_n, oe_n, we_n}));
endmodule

// File: tb/mem_zone_ctl_bench.sv
module mem_zone_ctl_bench;
    localparam int ROM_WS = 2, SRAM_WS = 1, IO_WS = 3, DRAM_RCD = 1, DRAM_CAS = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_start = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_ben = 2'b00;
    logic        cpu_wait, rom_sel_n, sram_sel_n, io_sel_n, cas_n, oe_n;
    logic [1:0]  ras_n, we_n;

    int vectors = 0, errors = 0, cycles = 0;
    bit done = 0;

    // reference state
    bit m_busy = 0;
    int m_rem = 0, m_zone = 5;
    bit m_wr = 0;
    logic [1:0] m_ben = 2'b00;

    always #4 clk = ~clk;

    mem_zone_ctl u_mem_zone_ctl (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_ben(cpu_ben), .cpu_wait(cpu_wait),
        .rom_sel_n(rom_sel_n), .sram_sel_n(sram_sel_n), .io_sel_n(io_sel_n),
        .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .we_n(we_n)
    );

    // 0 bank0, 1 bank1, 2 rom, 3 sram, 4 io, 5 local
    function automatic int ref_zone(input logic [23:0] a);
        if (a <= 24'h3FFFFF) return 0;
        if (a <= 24'h7FFFFF) return 1;
        if (a <= 24'hBFFFFF) return 2;
        if (a <= 24'hDFFFFF) return 3;
        if (a <= 24'hEFFFFF) return 4;
        return 5;
    endfunction

    function automatic int ref_wait(input int z);
        case (z)
            0, 1: return DRAM_RCD + DRAM_CAS;
            2: return ROM_WS;
            3: return SRAM_WS;
            4: return IO_WS;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_rem = 0;
        end else if (!m_busy && cpu_start) begin
            m_busy = 1; m_zone = ref_zone(cpu_addr); m_rem = ref_wait(m_zone);
            m_wr = cpu_wr; m_ben = cpu_ben;
        end else if (m_busy) begin
            if (m_rem == 0) m_busy = 0; else m_rem--;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        bit ext;
        logic [1:0] e_ras, e_we;
        logic [2:0] e_sel;
        cycles++;
        if (!rst && !done) begin
            ext   = m_busy && m_zone != 5;
            e_ras = 2'b11; e_sel = 3'b111;
            if (m_busy && m_zone == 0) e_ras[0] = 1'b0;
            if (m_busy && m_zone == 1) e_ras[1] = 1'b0;
            if (m_busy && m_zone == 2) e_sel[0] = 1'b0;
            if (m_busy && m_zone == 3) e_sel[1] = 1'b0;
            if (m_busy && m_zone == 4) e_sel[2] = 1'b0;
            e_we = (ext && m_wr) ? ~m_ben : 2'b11;
            chk("R1", "ras_n", ras_n, e_ras);
            chk("R2", "sel_n{io,sram,rom}", {io_sel_n, sram_sel_n, rom_sel_n}, e_sel);
            chk("R6", "cpu_wait", cpu_wait, m_busy && m_rem != 0);
            chk("R7", "cas_n", cas_n, !(m_busy && m_zone <= 1 && m_rem <= DRAM_CAS));
            chk("R4", "oe_n", oe_n, !(ext && !m_wr));
            chk("R5", "we_n", we_n, e_we);
        end
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic access(input logic [23:0] a, input bit wr, input logic [1:0] ben);
        cpu_addr = a; cpu_wr = wr; cpu_ben = ben; cpu_start = 1'b1;
        @(negedge clk);
        cpu_start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        logic [23:0] bounds [12];
        bounds = '{24'h000000, 24'h3FFFFF, 24'h400000, 24'h7FFFFF, 24'h800000, 24'hBFFFFF,
                   24'hC00000, 24'hDFFFFF, 24'hE00000, 24'hEFFFFF, 24'hF00000, 24'hFFFFFF};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "outputs after reset",
            {cpu_wait, rom_sel_n, sram_sel_n, io_sel_n, ras_n, cas_n, oe_n, we_n}, 10'b0111111111);
        rst = 1'b0;
        @(negedge clk);
        // R1 R2 R3 R4 R5: every boundary, both directions, all byte lanes
        foreach (bounds[i])
            for (int w = 0; w < 2; w++)
                for (int b = 0; b < 4; b++)
                    access(bounds[i], w[0], b[1:0]);
        // R9: start held high with a different address during a busy ROM access
        cpu_addr = 24'h900000; cpu_wr = 1'b1; cpu_ben = 2'b01; cpu_start = 1'b1;
        @(negedge clk);
        cpu_addr = 24'hC00010; cpu_wr = 1'b0; cpu_ben = 2'b10;
        repeat (8) @(negedge clk);
        cpu_start = 1'b0;
        while (m_busy) @(negedge clk);
        // R8: idle after all traffic, everything released
        @(negedge clk);
        chk("R8", "idle strobes",
            {rom_sel_n, sram_sel_n, io_sel_n, ras_n, cas_n, oe_n, we_n}, 9'h1FF);
        // back-to-back local then DRAM (R3)
        access(24'hF12345, 1'b1, 2'b11);
        access(24'h412345, 1'b1, 2'b10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule